// File: doc/BRIEF.md
# Programmable Stereo Sample Delay

This block holds back a stereo audio stream so the sound can be lined up with a video path that is slower. The left and right channels each carry 24-bit samples and each has its own valid/ready stream in and out. Each channel passes through its own circular buffer. The number of samples a channel lags is set separately for left and right, and the largest usable delay is 4095 samples. A delay can be given either as a direct sample count or as a number of video frames. In the frame case the block converts the frame count to samples from a table that is built when the design is elaborated.

The delay pins, the frame pin and the format pin are only staged. They are copied into the working settings on a single-cycle `commit` pulse. After each commit, a channel sends zeros until as many fresh samples as its new delay have gone in. This means data that was in the buffer before the commit never reaches the output. Two mute pins zero a channel's output data straight away, with no commit needed, and the output strobes keep their normal rate while muted.

Back-pressure rules, per channel:
- An output sample is held, unchanged, for as long as its `*_out_ready` is low.
- `*_in_ready` is high only when the output slot is empty or is being taken in that same cycle, and `commit` is low.
- An input is accepted in a cycle where `*_in_valid` and `*_in_ready` are both high.
- Each accepted input produces exactly one output, one cycle later.

Top module: `sample_delay`

## Requirements
- R1: Each channel's accepted output number k carries input number k−D, where D is that channel's committed delay. The left and right delays are independent.
- R2: In direct mode the 13-bit `cfg_dly_*` value N gives a delay of N samples. Any N above 4095 is limited to 4095. N = 0 returns each sample on the output in the cycle after it is accepted.
- R3: When `cfg_frame[7]`=1 the delay of both channels is floor(F × Fs / Fr), limited to 4095, where:
  - F = `cfg_frame[2:0]`+1.
  - Fr = 50 Hz when `cfg_frame[6]`=0 and 59.94 Hz (60000/1001) when it is 1.
  - Fs is set by `cfg_frame[5:3]`: 0 → 32000, 1 → 44100, 2 → 48000, 3 → 88200, 4 → 96000, 5 → 176400, 6 and 7 → 192000.
- R4: Changes on `cfg_dly_l`, `cfg_dly_r`, `cfg_frame` and `cfg_format` have no effect on the output until `commit` is pulsed.
- R5: After a commit, the first D accepted samples of a channel produce all-zero output data.
- R6: `cfg_mute_l` zeros the left output data and `cfg_mute_r` zeros the right output data, in the same cycle and without a commit. `*_out_valid` is not affected.
- R7: A committed `cfg_format` of 3 (pass-through) forces a delay of 0 on both channels, whatever the delay and frame settings are. Format values 0 to 2 leave the delay as programmed.
- R8: While `*_out_ready` is low, `*_out_valid` stays high and `*_out_data` stays stable, `*_in_ready` is low, and no sample is lost. `*_in_ready` is also low in a `commit` cycle.
- R9: After reset both outputs are not valid, both inputs are ready, and the working delays are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mute_l | input | 1 | Live left mute |
| cfg_mute_r | input | 1 | Live right mute |
| cfg_format | input | 2 | Staged stream format; 3 = pass-through |
| cfg_dly_l | input | 13 | Staged left delay in samples |
| cfg_dly_r | input | 13 | Staged right delay in samples |
| cfg_frame | input | 8 | Staged frame-mode setting |
| commit | input | 1 | One-cycle pulse that applies the staged settings |
| l_in_valid | input | 1 | Left input valid |
| l_in_ready | output | 1 | Left input ready |
| l_in_data | input | 24 | Left input sample |
| r_in_valid | input | 1 | Right input valid |
| r_in_ready | output | 1 | Right input ready |
| r_in_data | input | 24 | Right input sample |
| l_out_valid | output | 1 | Left output valid |
| l_out_ready | input | 1 | Left output ready |
| l_out_data | output | 24 | Left delayed sample |
| r_out_valid | output | 1 | Right output valid |
| r_out_ready | input | 1 | Right output ready |
| r_out_data | output | 24 | Right delayed sample |

## Verification
The hardest case to reach is the largest delay. It only shows at the ports after more than four thousand accepted samples, and it appears as the first non-zero output landing exactly on sample 4095. The bench reaches it in two ways: by committing an over-range direct value, and by committing a frame setting whose product overflows. In both cases it streams one sample per cycle past the boundary and compares every output against a reference history of the inputs it sent. The frame rate of 59.94 Hz is checked with settings whose exact product is a fraction, so that the floor step is visible in the delay.

// File: rtl/sdel_pkg.sv
package sdel_pkg;
  localparam int SAMPLE_W = 24;
  localparam int CFG_W    = 13;
  localparam int FRAME_SEL_W = 7;

  // Samples for a frame selector: [6] 59.94 Hz, [5:3] rate code, [2:0] frames-1.
  function automatic int unsigned frame_samples(input int unsigned sel, input int unsigned cap);
    longint unsigned rate;
    longint unsigned num;
    longint unsigned den;
    longint unsigned v;
    longint unsigned frames;
    frames = longint'(sel & 7) + 1;
    case ((sel >> 3) & 7)
      0: rate = 32000;
      1: rate = 44100;
      2: rate = 48000;
      3: rate = 88200;
      4: rate = 96000;
      5: rate = 176400;
      default: rate = 192000;
    endcase
    if ((sel & 64) != 0) begin
      num = rate * frames * 1001;
      den = 60000;
    end else begin
      num = rate * frames;
      den = 50;
    end
    v = num / den;
    if (v > longint'(cap)) v = longint'(cap);
    return int'(v);
  endfunction
endpackage

// File: rtl/sdel_settings.sv
module sdel_settings #(
  parameter int MAX_DELAY = 4095,
  parameter int AW        = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [1:0]               cfg_format,
  input  logic [sdel_pkg::CFG_W-1:0] cfg_dly_l,
  input  logic [sdel_pkg::CFG_W-1:0] cfg_dly_r,
  input  logic [7:0]               cfg_frame,
  output logic [AW-1:0]            act_dly_l,
  output logic [AW-1:0]            act_dly_r
);
  localparam int TAB_N = 2 ** sdel_pkg::FRAME_SEL_W;

  logic [AW-1:0] frame_tab [TAB_N];

  // Frame-to-sample table, computed at elaboration (no divider in hardware).
  for (genvar g = 0; g < TAB_N; g++) begin : g_ftab
    localparam int unsigned FV = sdel_pkg::frame_samples(g, MAX_DELAY);
    assign frame_tab[g] = AW'(FV);
  end

  function automatic logic [AW-1:0] limit(input logic [sdel_pkg::CFG_W-1:0] v);
    if (32'(v) > MAX_DELAY) return AW'(MAX_DELAY);
    return AW'(v);
  endfunction

  logic          pass_thru;
  logic [AW-1:0] nxt_l, nxt_r;

  always_comb begin
    pass_thru = (cfg_format == 2'd3);
    if (pass_thru) begin
      nxt_l = '0;
      nxt_r = '0;
    end else if (cfg_frame[7]) begin
      nxt_l = frame_tab[cfg_frame[6:0]];
      nxt_r = frame_tab[cfg_frame[6:0]];
    end else begin
      nxt_l = limit(cfg_dly_l);
      nxt_r = limit(cfg_dly_r);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_dly_l <= '0;
      act_dly_r <= '0;
    end else if (commit) begin
      act_dly_l <= nxt_l;
      act_dly_r <= nxt_r;
    end
  end

  // R4: working settings move only on a commit
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(act_dly_l) && $stable(act_dly_r)));
endmodule

// File: rtl/sdel_line.sv
module sdel_line #(
  parameter int SAMPLE_W = 24,
  parameter int AW       = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit,
  input  logic [AW-1:0]       delay,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_data
);
  localparam int DEPTH = 2 ** AW;

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [AW-1:0]       wr_ptr;
  logic [AW-1:0]       fill;
  logic [AW-1:0]       rd_ptr;
  logic [SAMPLE_W-1:0] rd_data;
  logic                filling;
  logic                accept;

  assign in_ready = (!out_valid || out_ready) && !commit;
  assign accept   = in_valid && in_ready;
  assign rd_ptr   = wr_ptr - delay;
  assign filling  = (fill < delay);
  assign rd_data  = (delay == '0) ? in_data : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      fill      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (accept) begin
        wr_ptr   <= wr_ptr + 1'b1;
        out_data <= filling ? '0 : rd_data;
        if (filling) fill <= fill + 1'b1;
      end
      if (commit) fill <= '0;
      if (accept)         out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  // R5: the fill count never passes the working delay
  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= delay);

  // R8: a stalled output keeps its strobe and data
  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2: zero delay returns the accepted sample on the next cycle
  assert_zero_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && delay == '0) |=> (out_data == $past(in_data)));
endmodule

// File: rtl/sample_delay.sv
module sample_delay #(
  parameter int SAMPLE_W  = sdel_pkg::SAMPLE_W,
  parameter int MAX_DELAY = 4095
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_mute_l,
  input  logic                       cfg_mute_r,
  input  logic [1:0]                 cfg_format,
  input  logic [sdel_pkg::CFG_W-1:0] cfg_dly_l,
  input  logic [sdel_pkg::CFG_W-1:0] cfg_dly_r,
  input  logic [7:0]                 cfg_frame,
  input  logic                       commit,
  input  logic                       l_in_valid,
  output logic                       l_in_ready,
  input  logic [SAMPLE_W-1:0]        l_in_data,
  input  logic                       r_in_valid,
  output logic                       r_in_ready,
  input  logic [SAMPLE_W-1:0]        r_in_data,
  output logic                       l_out_valid,
  input  logic                       l_out_ready,
  output logic [SAMPLE_W-1:0]        l_out_data,
  output logic                       r_out_valid,
  input  logic                       r_out_ready,
  output logic [SAMPLE_W-1:0]        r_out_data
);
  localparam int AW = $clog2(MAX_DELAY + 1);

  logic [AW-1:0]       act_dly_l, act_dly_r;
  logic [SAMPLE_W-1:0] line_l, line_r;

  sdel_settings #(.MAX_DELAY(MAX_DELAY), .AW(AW)) i_settings (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .cfg_format(cfg_format),
    .cfg_dly_l (cfg_dly_l),
    .cfg_dly_r (cfg_dly_r),
    .cfg_frame (cfg_frame),
    .act_dly_l (act_dly_l),
    .act_dly_r (act_dly_r)
  );

  sdel_line #(.SAMPLE_W(SAMPLE_W), .AW(AW)) i_line_l (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .delay    (act_dly_l),
    .in_valid (l_in_valid),
    .in_ready (l_in_ready),
    .in_data  (l_in_data),
    .out_valid(l_out_valid),
    .out_ready(l_out_ready),
    .out_data (line_l)
  );

  sdel_line #(.SAMPLE_W(SAMPLE_W), .AW(AW)) i_line_r (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .delay    (act_dly_r),
    .in_valid (r_in_valid),
    .in_ready (r_in_ready),
    .in_data  (r_in_data),
    .out_valid(r_out_valid),
    .out_ready(r_out_ready),
    .out_data (line_r)
  );

  // Live mute gating (R6): applies without a commit, strobes untouched.
  assign l_out_data = cfg_mute_l ? '0 : line_l;
  assign r_out_data = cfg_mute_r ? '0 : line_r;
endmodule

// File: tb/test_sample_delay.sv
`timescale 1ns/1ps
module test_sample_delay;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        cfg_mute_l, cfg_mute_r, commit;
  logic [1:0]  cfg_format;
  logic [12:0] cfg_dly_l, cfg_dly_r;
  logic [7:0]  cfg_frame;
  logic        l_in_valid, l_in_ready, r_in_valid, r_in_ready;
  logic [23:0] l_in_data, r_in_data, l_out_data, r_out_data;
  logic        l_out_valid, l_out_ready, r_out_valid, r_out_ready;

  sample_delay i_sample_delay (
    .clk(clk), .rst_n(rst_n), .cfg_mute_l(cfg_mute_l), .cfg_mute_r(cfg_mute_r),
    .cfg_format(cfg_format), .cfg_dly_l(cfg_dly_l), .cfg_dly_r(cfg_dly_r),
    .cfg_frame(cfg_frame), .commit(commit),
    .l_in_valid(l_in_valid), .l_in_ready(l_in_ready), .l_in_data(l_in_data),
    .r_in_valid(r_in_valid), .r_in_ready(r_in_ready), .r_in_data(r_in_data),
    .l_out_valid(l_out_valid), .l_out_ready(l_out_ready), .l_out_data(l_out_data),
    .r_out_valid(r_out_valid), .r_out_ready(r_out_ready), .r_out_data(r_out_data)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [23:0] hist_l [8192];
  logic [23:0] hist_r [8192];
  int cnt_l = 0, cnt_r = 0, d_l = 0, d_r = 0, gseq = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Streams n samples on both channels, one per cycle, checking each output.
  task automatic push(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      logic [23:0] vl, vr, el, er;
      vl = 24'(gseq * 3 + 1);
      vr = 24'h800000 | 24'(gseq);
      gseq++;
      l_in_valid = 1'b1; r_in_valid = 1'b1;
      l_in_data = vl;    r_in_data = vr;
      @(negedge clk);
      hist_l[cnt_l] = vl;
      hist_r[cnt_r] = vr;
      el = (cfg_mute_l || cnt_l < d_l) ? 24'd0 : hist_l[cnt_l - d_l];
      er = (cfg_mute_r || cnt_r < d_r) ? 24'd0 : hist_r[cnt_r - d_r];
      cnt_l++; cnt_r++;
      check(req, {7'd0, l_out_valid, l_out_data}, {7'd0, 1'b1, el});
      check(req, {7'd0, r_out_valid, r_out_data}, {7'd0, 1'b1, er});
    end
    l_in_valid = 1'b0; r_in_valid = 1'b0;
  endtask

  task automatic do_commit(input int el, input int er);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    cnt_l = 0; cnt_r = 0;
    d_l = el;  d_r = er;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R9 out_valid after reset", {30'd0, l_out_valid, r_out_valid}, 32'd0);
    check("R9 in_ready after reset", {30'd0, l_in_ready, r_in_ready}, 32'd3);
    push(4, "R9 zero working delay");
  endtask

  task automatic t_direct();
    cfg_dly_l = 13'd35; cfg_dly_r = 13'd300;
    do_commit(35, 300);
    push(320, "R1 R5 independent delays");
  endtask

  task automatic t_no_commit();
    cfg_dly_l = 13'd7; cfg_dly_r = 13'd9; cfg_frame = 8'h80; cfg_format = 2'd3;
    push(20, "R4 staged change ignored");
    cfg_frame = 8'h00; cfg_format = 2'd0;
  endtask

  task automatic t_limits();
    cfg_dly_l = 13'd0; cfg_dly_r = 13'd1;
    do_commit(0, 1);
    push(6, "R2 zero and one sample");
    cfg_dly_l = 13'd5000; cfg_dly_r = 13'd8191;
    do_commit(4095, 4095);
    push(4100, "R2 limit 4095");
  endtask

  task automatic t_frames();
    cfg_frame = 8'b1_0_000_000;  // 50 Hz, 32 kHz, 1 frame -> 640
    do_commit(640, 640);
    push(650, "R3 50Hz 32k one frame");
    cfg_frame = 8'b1_1_010_000;  // 59.94 Hz, 48 kHz, 1 frame -> 800
    do_commit(800, 800);
    push(810, "R3 59.94Hz 48k one frame");
    cfg_frame = 8'b1_1_001_010;  // 59.94 Hz, 44.1 kHz, 3 frames -> 2207
    do_commit(2207, 2207);
    push(2215, "R3 59.94Hz 44.1k three frames");
    cfg_frame = 8'b1_0_110_111;  // 50 Hz, 192 kHz, 8 frames -> limited
    do_commit(4095, 4095);
    push(4100, "R3 frame result limited");
    cfg_frame = 8'h00;
  endtask

  task automatic t_bypass();
    cfg_dly_l = 13'd100; cfg_dly_r = 13'd200; cfg_format = 2'd3;
    do_commit(0, 0);
    push(5, "R7 pass-through format");
    cfg_format = 2'd1;
    do_commit(100, 200);
    push(210, "R7 normal format keeps delay");
    cfg_format = 2'd0;
  endtask

  task automatic t_mute();
    cfg_mute_l = 1'b1;
    push(6, "R6 left mute");
    cfg_mute_l = 1'b0; cfg_mute_r = 1'b1;
    push(6, "R6 right mute");
    cfg_mute_r = 1'b0;
    push(2, "R6 unmuted");
    cfg_mute_r = 1'b1;
    #1;
    check("R6 immediate mute data", {8'd0, r_out_data}, 32'd0);
    check("R6 strobe continues", {31'd0, r_out_valid}, 32'd1);
    cfg_mute_r = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_backpressure();
    logic [23:0] held, vl, el;
    push(3, "R8 prime");
    held = l_out_data;
    l_out_ready = 1'b0;
    vl = 24'(gseq * 3 + 1); gseq++;
    l_in_valid = 1'b1; l_in_data = vl;
    #1;
    check("R8 in_ready low on stall", {31'd0, l_in_ready}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 held valid", {31'd0, l_out_valid}, 32'd1);
      check("R8 held data", {8'd0, l_out_data}, {8'd0, held});
      check("R8 in_ready stays low", {31'd0, l_in_ready}, 32'd0);
    end
    l_out_ready = 1'b1;
    @(negedge clk);
    l_in_valid = 1'b0;
    hist_l[cnt_l] = vl;
    el = (cnt_l < d_l) ? 24'd0 : hist_l[cnt_l - d_l];
    cnt_l++;
    check("R8 no sample lost", {8'd0, l_out_data}, {8'd0, el});
    commit = 1'b1;
    #1;
    check("R8 in_ready low in commit cycle", {30'd0, l_in_ready, r_in_ready}, 32'd0);
    @(negedge clk);
    commit = 1'b0;
    cnt_l = 0; cnt_r = 0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; commit = 1'b0;
    cfg_mute_l = 1'b0; cfg_mute_r = 1'b0; cfg_format = 2'd0;
    cfg_dly_l = '0; cfg_dly_r = '0; cfg_frame = '0;
    l_in_valid = 1'b0; r_in_valid = 1'b0; l_in_data = '0; r_in_data = '0;
    l_out_ready = 1'b1; r_out_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_no_commit();
    t_limits();
    t_frames();
    t_bypass();
    t_mute();
    t_backpressure();
    finish_run();
  end
endmodule